// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block is a bus master for a serial link with one clock wire and one shared data wire. A transfer runs in two phases. In the first phase the master drives the data wire and shifts out a number of 32-bit words. It then releases the wire, and in the second phase the peripheral drives the data back. Chip select stays low for both phases. A plain write sends N words and reads back one status word. A command-read sends one command word and reads back M response words and then the status word. Both are the same request with different word counts.

The bus runs from a stepping rate set by an integer divider of the block clock. One bit of the bus takes two steps. The turnaround and the sampling edge come in three variants, one for each speed class. The variant is chosen from the resulting step frequency. When the read phase ends, the master keeps the clock low and waits for the peripheral to pull the data wire high as an event signal. It then pulses an interrupt. Outgoing words arrive on a valid/ready stream. Received words leave on a valid strobe that has no backpressure, and the final word of the transfer is marked.

Top module: `tw_spi_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, dio_oe is 1, dio_out is 0, and busy, tx_ready and event_irq are all 0.
- R2: In the write phase, sclk rises exactly 32 times for each write word while dio_oe is 1. Each bit is on dio_out while sclk is low and is taken on the rising edge. Bit 31 of each word goes out first.
- R3: tx_ready is 1 only while a fresh write word is needed. While tx_valid stays 0 in that state, sclk stays low and produces no edges.
- R4: At turnaround, dio_oe falls while sclk is 0. In low-speed mode (code 0), one more low step follows, and dio_in is captured at the end of each high step. In high-speed mode (code 1), one high step follows, and dio_in is captured at the end of each low step, at the rise. In overclock mode (code 2), a high step and a low step follow, and capture is at the end of each high step.
- R5: 32 bits are read for each read word, with the first bit going to bit 31. Each completed word appears on rx_data for one cycle with rx_valid. rx_last is 1 only with the final word, which is the status word.
- R6: From the cycle after an accepted request, busy is 1 and cs_n is 0. Both return when the last read bit ends.
- R7: The mode comes from SYS_HZ divided by the divider. Above 100 MHz gives overclock. From 75 MHz up to and including 100 MHz gives high-speed. Anything lower gives low-speed.
- R8: One step lasts clk_div clock cycles, with 0 treated as 1. The sclk period inside a word is therefore 2 × clk_div cycles.
- R9: After the read phase, sclk stays 0 and event_irq stays 0 until dio_in is 1. event_irq then pulses for exactly one cycle, in the cycle after dio_in is seen high.
- R10: A request that arrives while busy is 1 is ignored. The transfer in progress keeps its word counts.
- R11: A request that arrives while the master waits for the event is accepted and ends the wait. If dio_in is high in that same cycle, event_irq still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Step divider, taken when a request is accepted |
| req_valid | input | 1 | Transfer request |
| req_wr_words | input | CNT_W | Number of words to send (at least 1) |
| req_rd_words | input | CNT_W | Number of words to receive, status word included (at least 1) |
| busy | output | 1 | Transfer in progress |
| tx_data | input | WORD_W | Outgoing word |
| tx_valid | input | 1 | Outgoing word is present |
| tx_ready | output | 1 | Master takes the outgoing word |
| rx_data | output | WORD_W | Received word |
| rx_valid | output | 1 | rx_data holds a completed word |
| rx_last | output | 1 | This word is the final (status) word |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Bus clock |
| dio_out | output | 1 | Data value driven onto the shared wire |
| dio_oe | output | 1 | Output enable for the shared wire |
| dio_in | input | 1 | Value read from the shared wire |
| event_irq | output | 1 | One-cycle event interrupt |

## Verification
The master leaves the event wait in one of two ways: the peripheral raises the data wire, or a new request arrives. Both can land on the same clock edge. The bench provokes this by driving dio_in high and req_valid at the same falling edge while the master waits. One cycle later it requires event_irq to be 1 and busy to be 1 together. It then lets the new transfer finish and compares every sent and received bit. This shows that the wait ended cleanly and that the new transfer started from fresh counts.

// File: rtl/tw_spi_pkg.sv
package tw_spi_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'd0,
        MODE_HIGH = 2'd1,
        MODE_OVER = 2'd2
    } rd_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WLO,
        ST_WHI,
        ST_TURN,
        ST_TA1,
        ST_TA2,
        ST_RA,
        ST_RB,
        ST_WAIT
    } st_e;

    localparam int unsigned OVER_MIN_HZ = 100_000_000;
    localparam int unsigned HIGH_MIN_HZ = 75_000_000;

    // Speed class from block clock and integer step divider (0 acts as 1)
    function automatic rd_mode_e pick_mode(input int unsigned sys_hz, input int unsigned div);
        int unsigned d;
        int unsigned eff;
        d   = (div == 0) ? 1 : div;
        eff = sys_hz / d;
        if (eff > OVER_MIN_HZ)       return MODE_OVER;
        else if (eff >= HIGH_MIN_HZ) return MODE_HIGH;
        else                         return MODE_LOW;
    endfunction

    // Clock level during the capture step of a read bit
    function automatic logic capture_level(input rd_mode_e m);
        return (m != MODE_HIGH);
    endfunction

endpackage

// File: rtl/tw_spi_tick.sv
module tw_spi_tick #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - 1'b1;
    assign tick = !hold && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || hold) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    // R8: with a divider above one, steps never come on consecutive cycles
    a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (tick && div > 1) |=> !tick);

endmodule

// File: rtl/tw_spi_shreg.sv
module tw_spi_shreg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (load)  q <= load_val;
        else if (shift) q <= {q[W-2:0], shin};
    end
endmodule

// File: rtl/tw_spi_master.sv
module tw_spi_master
    import tw_spi_pkg::*;
#(
    parameter int unsigned SYS_HZ = 150_000_000,
    parameter int          WORD_W = 32,
    parameter int          CNT_W  = 8,
    parameter int          DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    input  logic [CNT_W-1:0]  req_wr_words,
    input  logic [CNT_W-1:0]  req_rd_words,
    output logic              busy,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_last,
    output logic              cs_n,
    output logic              sclk,
    output logic              dio_out,
    output logic              dio_oe,
    input  logic              dio_in,
    output logic              event_irq
);
    localparam int LSB_W = $clog2(WORD_W);
    localparam int BIT_W = CNT_W + LSB_W;
    localparam logic [LSB_W-1:0] LSB_ZERO = '0;

    st_e               st;
    logic [BIT_W-1:0]  xcnt, ycnt;
    logic [DIV_W-1:0]  div_q;
    rd_mode_e          mode;
    logic              oe_q, cs_q, irq_q, rxv_q, rxl_q;
    logic              accept, hold, tick, samp_lvl;
    logic [WORD_W-1:0] tx_q;

    assign accept   = req_valid && (st == ST_IDLE || st == ST_WAIT);
    assign hold     = (st == ST_IDLE) || (st == ST_LOAD) || (st == ST_WAIT);
    assign mode     = pick_mode(SYS_HZ, 32'(div_q));
    assign samp_lvl = capture_level(mode);

    tw_spi_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .hold(hold), .div(div_q), .tick(tick)
    );

    tw_spi_shreg #(.W(WORD_W)) u_tx (
        .clk(clk), .rst(rst),
        .load(st == ST_LOAD && tx_valid), .load_val(tx_data),
        .shift(st == ST_WHI && tick), .shin(1'b0), .q(tx_q)
    );

    tw_spi_shreg #(.W(WORD_W)) u_rx (
        .clk(clk), .rst(rst),
        .load(accept), .load_val('0),
        .shift(st == ST_RA && tick), .shin(dio_in), .q(rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            xcnt  <= '0;
            ycnt  <= '0;
            div_q <= '0;
            oe_q  <= 1'b1;
            cs_q  <= 1'b1;
            irq_q <= 1'b0;
            rxv_q <= 1'b0;
            rxl_q <= 1'b0;
        end else begin
            irq_q <= (st == ST_WAIT) && dio_in;
            rxv_q <= 1'b0;
            rxl_q <= 1'b0;
            if (accept) begin
                st    <= ST_LOAD;
                xcnt  <= {req_wr_words, LSB_ZERO} - BIT_W'(1);
                ycnt  <= {req_rd_words, LSB_ZERO} - BIT_W'(1);
                div_q <= clk_div;
                oe_q  <= 1'b1;
                cs_q  <= 1'b0;
            end else begin
                case (st)
                    ST_WAIT: if (dio_in) st <= ST_IDLE;
                    ST_LOAD: if (tx_valid) st <= ST_WLO;
                    ST_WLO:  if (tick) st <= ST_WHI;
                    ST_WHI: if (tick) begin
                        if (xcnt == '0) begin
                            st   <= ST_TURN;
                            oe_q <= 1'b0;
                        end else begin
                            xcnt <= xcnt - 1'b1;
                            st   <= (xcnt[LSB_W-1:0] == '0) ? ST_LOAD : ST_WLO;
                        end
                    end
                    ST_TURN: if (tick) st <= ST_TA1;
                    ST_TA1:  if (tick) st <= (mode == MODE_OVER) ? ST_TA2 : ST_RA;
                    ST_TA2:  if (tick) st <= ST_RA;
                    ST_RA: if (tick) begin
                        st <= ST_RB;
                        if (ycnt[LSB_W-1:0] == '0) begin
                            rxv_q <= 1'b1;
                            rxl_q <= (ycnt == '0);
                        end
                    end
                    ST_RB: if (tick) begin
                        if (ycnt == '0) begin
                            st   <= ST_WAIT;
                            cs_q <= 1'b1;
                        end else begin
                            ycnt <= ycnt - 1'b1;
                            st   <= ST_RA;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (st)
            ST_WHI:  sclk = 1'b1;
            ST_TA1:  sclk = (mode != MODE_LOW);
            ST_RA:   sclk = samp_lvl;
            ST_RB:   sclk = !samp_lvl;
            default: sclk = 1'b0;
        endcase
    end

    assign dio_oe    = oe_q;
    assign dio_out   = oe_q & tx_q[WORD_W-1];
    assign tx_ready  = (st == ST_LOAD);
    assign busy      = !(st == ST_IDLE || st == ST_WAIT);
    assign cs_n      = cs_q;
    assign event_irq = irq_q;
    assign rx_valid  = rxv_q;
    assign rx_last   = rxl_q;

    // R6: a running transfer always holds chip select low
    a_r6_cs_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cs_n);

    // R5: received words appear only while the wire is released
    a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !dio_oe);

    // R9: the interrupt follows a high data line
    a_r9_irq_after_line: assert property (@(posedge clk) disable iff (rst)
        event_irq |-> $past(dio_in));

    // R3: outgoing words are taken only while driving under chip select
    a_r3_ready_driving: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (dio_oe && !cs_n));

    // R4: the wire is released with the clock low
    a_r4_turn_clock_low: assert property (@(posedge clk) disable iff (rst)
        $fell(dio_oe) |-> !sclk);

    // R9: outside a transfer the clock rests low
    a_r9_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk);

endmodule

// File: tb/sim_tw_spi_master.sv
module sim_tw_spi_master;
    import tw_spi_pkg::*;

    localparam int CW = 8;
    localparam int DW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [DW-1:0] clk_div = '0;
    logic          req_valid = 1'b0;
    logic [CW-1:0] req_wr_words = '0, req_rd_words = '0;
    logic          busy, tx_ready, rx_valid, rx_last, cs_n, sclk, dio_out, dio_oe, event_irq;
    logic [31:0]   tx_data, rx_data;
    logic          tx_valid, dio_in;

    // stimulus and model state
    logic [31:0] wr_pat [8];
    logic [31:0] rd_pat [8];
    logic [31:0] wr_cap [8];
    logic [31:0] rx_cap [8];
    int       n_wr = 0, n_rd = 0;
    bit       tx_hold = 0;
    logic     ev_line = 1'b0;
    rd_mode_e exp_mode = MODE_LOW;
    int  tx_idx = 0, wr_bits = 0, rx_n = 0, last_n = 0, last_pos = -1;
    int  n_rise = 0, turn_seen = 0, rd_idx = 0, skip = 0, cyc = 0;
    int  t_rise [2];
    bit  acc_pend = 0, turn_ok = 1, rd_act = 0;
    logic pbit = 1'b0, prev_sclk = 1'b0, prev_oe = 1'b1;

    int n_tests = 0, n_fail = 0;

    assign tx_valid = !tx_hold && (tx_idx < n_wr);
    assign tx_data  = wr_pat[tx_idx % 8];
    assign dio_in   = rd_act ? pbit : ev_line;

    tw_spi_master #(.SYS_HZ(150_000_000), .WORD_W(32), .CNT_W(CW), .DIV_W(DW)) u0 (
        .clk(clk), .rst(rst), .clk_div(clk_div), .req_valid(req_valid),
        .req_wr_words(req_wr_words), .req_rd_words(req_rd_words), .busy(busy),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
        .cs_n(cs_n), .sclk(sclk), .dio_out(dio_out), .dio_oe(dio_oe),
        .dio_in(dio_in), .event_irq(event_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Peripheral model: observes the bus between clock edges
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            rd_act = 0; prev_sclk = 1'b0; prev_oe = 1'b1;
        end else begin
            if (req_valid && !busy) begin
                wr_bits = 0; rx_n = 0; last_n = 0; last_pos = -1; n_rise = 0;
                tx_idx = 0; acc_pend = 0; turn_seen = 0; turn_ok = 1; rd_act = 0;
                for (int i = 0; i < 8; i++) wr_cap[i] = '0;
            end else begin
                if (acc_pend) tx_idx++;
                acc_pend = tx_ready && tx_valid;
                if (!cs_n && dio_oe && sclk && !prev_sclk) begin
                    wr_cap[(wr_bits >> 5) % 8] = {wr_cap[(wr_bits >> 5) % 8][30:0], dio_out};
                    if (n_rise < 2) t_rise[n_rise] = cyc;
                    n_rise++;
                    wr_bits++;
                end
                if (rd_act && ((exp_mode == MODE_HIGH) ? (sclk && !prev_sclk)
                                                        : (!sclk && prev_sclk))) begin
                    if (skip > 0) skip--;
                    else begin
                        rd_idx++;
                        if (rd_idx < n_rd * 32) pbit = rd_pat[(rd_idx >> 5) % 8][31 - (rd_idx % 32)];
                        else rd_act = 0;
                    end
                end
                if (prev_oe && !dio_oe && !cs_n) begin
                    turn_seen++;
                    if (sclk) turn_ok = 0;
                    rd_act = 1; rd_idx = 0;
                    skip = (exp_mode == MODE_LOW) ? 0 : 1;
                    pbit = rd_pat[0][31];
                end
                if (rx_valid) begin
                    rx_cap[rx_n % 8] = rx_data;
                    if (rx_last) begin last_n++; last_pos = rx_n; end
                    rx_n++;
                end
            end
            prev_sclk = sclk;
            prev_oe   = dio_oe;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        forever begin
            @(negedge clk);
            if (cyc > 150000) begin
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
                finish_run();
            end
        end
    end

    task automatic check_reset();
        chk(cs_n == 1'b1,     "R1", "cs_n",      cs_n, 1);
        chk(sclk == 1'b0,     "R1", "sclk",      sclk, 0);
        chk(dio_oe == 1'b1,   "R1", "dio_oe",    dio_oe, 1);
        chk(dio_out == 1'b0,  "R1", "dio_out",   dio_out, 0);
        chk(busy == 1'b0,     "R1", "busy",      busy, 0);
        chk(tx_ready == 1'b0, "R1", "tx_ready",  tx_ready, 0);
        chk(event_irq == 1'b0,"R1", "event_irq", event_irq, 0);
    endtask

    task automatic check_mode_pick();
        chk(pick_mode(200_000_000, 2) == MODE_HIGH, "R7", "100 MHz class", pick_mode(200_000_000, 2), MODE_HIGH);
        chk(pick_mode(201_000_000, 2) == MODE_OVER, "R7", "100.5 MHz class", pick_mode(201_000_000, 2), MODE_OVER);
        chk(pick_mode(150_000_000, 2) == MODE_HIGH, "R7", "75 MHz class", pick_mode(150_000_000, 2), MODE_HIGH);
        chk(pick_mode(133_000_000, 2) == MODE_LOW,  "R7", "66.5 MHz class", pick_mode(133_000_000, 2), MODE_LOW);
    endtask

    // One transfer; options: stall the stream, poke while busy, start on an event
    task automatic run_xfer(input int div, input int nw, input int nr, input logic [31:0] seed,
                            input rd_mode_e em, input bit stall, input bit poke, input bit ev_same);
        int eff = (div == 0) ? 1 : div;
        int guard;
        for (int i = 0; i < 8; i++) begin
            wr_pat[i] = seed ^ (32'h9E37_79B9 * (i + 1));
            rd_pat[i] = ~seed + (32'h0101_0107 * (i + 3));
        end
        rd_pat[0][31] = 1'b1;
        exp_mode = em; n_wr = nw; n_rd = nr;
        clk_div = DW'(div); req_wr_words = CW'(nw); req_rd_words = CW'(nr);
        @(negedge clk);
        req_valid = 1'b1;
        if (ev_same) ev_line = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (ev_same) begin
            ev_line = 1'b0;
            chk(event_irq == 1'b1, "R11", "irq with new request", event_irq, 1);
        end
        chk(busy == 1'b1, "R6", "busy after accept", busy, 1);
        chk(cs_n == 1'b0, "R6", "cs_n after accept", cs_n, 0);
        if (poke) begin
            repeat (5) @(negedge clk);
            req_wr_words = CW'(nw + 2); req_rd_words = CW'(nr + 2); req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (stall) begin
            guard = 0;
            while (tx_idx < 1 && guard < 5000) begin @(negedge clk); guard++; end
            tx_hold = 1;
            guard = 0;
            while (!tx_ready && guard < 5000) begin @(negedge clk); guard++; end
            begin
                int rises0 = n_rise;
                bit quiet = 1;
                repeat (20) begin
                    @(negedge clk);
                    if (sclk || !tx_ready) quiet = 0;
                end
                #1;
                chk(quiet, "R3", "clock low and ready held in stall", quiet, 1);
                chk(n_rise == rises0, "R3", "no edges in stall", n_rise, rises0);
            end
            tx_hold = 0;
        end
        guard = 0;
        while (!cs_n && guard < 20000) begin @(negedge clk); guard++; end
        #1;
        chk(busy == 1'b0, "R6", "busy at end", busy, 0);
        chk(wr_bits == 32 * nw, "R10", "write bit count", wr_bits, 32 * nw);
        for (int i = 0; i < nw; i++)
            chk(wr_cap[i] == wr_pat[i], "R2", "sent word", wr_cap[i], wr_pat[i]);
        chk(turn_seen == 1 && turn_ok, "R4", "release with clock low", turn_seen, 1);
        chk(rx_n == nr, "R5", "received word count", rx_n, nr);
        for (int i = 0; i < nr; i++)
            chk(rx_cap[i] == rd_pat[i], "R4", "received word at mode edge", rx_cap[i], rd_pat[i]);
        chk(last_n == 1 && last_pos == nr - 1, "R5", "last flag position", last_pos, nr - 1);
        chk(t_rise[1] - t_rise[0] == 2 * eff, "R8", "sclk period", t_rise[1] - t_rise[0], 2 * eff);
    endtask

    task automatic check_event();
        repeat (3) @(negedge clk);
        chk(event_irq == 1'b0, "R9", "irq before event", event_irq, 0);
        chk(sclk == 1'b0, "R9", "clock held low in wait", sclk, 0);
        ev_line = 1'b1;
        @(negedge clk);
        chk(event_irq == 1'b1, "R9", "irq pulse", event_irq, 1);
        ev_line = 1'b0;
        @(negedge clk);
        chk(event_irq == 1'b0, "R9", "irq one cycle", event_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset();
        check_mode_pick();
        // high-speed class, plain write with a stalled stream
        run_xfer(2, 2, 1, 32'hA5C3_0F91, MODE_HIGH, 1, 0, 0);
        check_event();
        // low-speed class, command-read, request poked while busy
        run_xfer(3, 1, 3, 32'h1234_5678, MODE_LOW, 0, 1, 0);
        check_event();
        // overclock class, then a request landing on the event cycle
        run_xfer(1, 1, 2, 32'hDEAD_BEEF, MODE_OVER, 0, 0, 0);
        repeat (2) @(negedge clk);
        run_xfer(1, 1, 1, 32'h0F0F_7E81, MODE_OVER, 0, 0, 1);
        check_event();
        // divider code 0 behaves as 1
        run_xfer(0, 1, 1, 32'h8000_0001, MODE_OVER, 0, 0, 0);
        check_event();
        finish_run();
    end

endmodule